// File: doc/BRIEF.md
# Three-Register Combined Pseudo-Random Bit Generator

The block produces one pseudo-random bit per enabled clock by XOR-ing the last stage of three free-running maximal-length shift registers of different lengths. Because the three periods are pairwise coprime, the combined stream repeats only after the product of the three periods. Only the last stage of each register is used in each step, since its other stages just hold delayed copies of that bit. A word of `WORD_W` bits is assembled from successive output bits, and a one-cycle strobe marks each finished word.

At start-up the registers can be filled serially from an external entropy bit, such as a sampled oscillator phase. The three registers form one serial chain for this fill, so the register lengths do not change. Alternatively, a fixed debug seed can be forced so that the sequence repeats run to run. The entropy input is only used while filling. A register left all-zero after a fill is forced out of the lock-up state.

Top module: `rng_combo_top`

## Requirements
- R1: While rst_ni is low, bit_o, word_o and word_valid_o are 0 and the three registers hold their debug seeds.
- R2: Each register of length L steps as s <= {s[L-2:0], ^(s & TAPS)}. Its output is s[L-1]. TAPS has at most four set bits, and the default masks give maximal length.
- R3: On each enabled step, bit_o is updated at that clock edge to the XOR of the three registers' s[L-1] values taken before the edge.
- R4: Every WORD_W enabled steps, word_valid_o is high for one cycle. word_o then holds those WORD_W bits, with the first bit of the group in bit 0 and the last in bit WORD_W-1. word_o keeps this value until the next word is complete.
- R5: With en_i low and no fill, debug load or zero fix pending, no register steps and bit_o and word_o keep their values.
- R6: While seed_valid_i is high, on each clock seed_bit_i enters bit 0 of register A. A[LA-1] enters bit 0 of B, and B[LB-1] enters bit 0 of C.
- R7: While seed_valid_i or debug_seed_sel_i is high, bit_o and word_o are held, word_valid_o is 0, and the word bit count restarts from zero.
- R8: While debug_seed_sel_i is high, each register is loaded with its debug seed on every clock. This takes priority over seed_valid_i.
- R9: Outside fill and debug load, a register that is all zero is set to 1 on the next clock. No step is taken in that cycle.
- R10: With the default masks, the combined bit stream has a period equal to the product (2^LA-1)(2^LB-1)(2^LC-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_bit_i | input | 1 | Serial entropy bit for the fill |
| seed_valid_i | input | 1 | Shift seed_bit_i into the register chain |
| debug_seed_sel_i | input | 1 | Force fixed debug seeds |
| en_i | input | 1 | Step enable |
| bit_o | output | 1 | Combined random bit |
| word_o | output | WORD_W | Packed word of successive bits |
| word_valid_o | output | 1 | One-cycle strobe for a new word |

## Verification
The bench builds the block with register lengths 3, 4 and 5 and masks for maximal sequences, giving periods 7, 15 and 31. The full combined period of 3255 steps therefore fits in one run. The bench checks that the stream repeats at that lag and not at the lags 3255/3, 3255/5 and 3255/7. A 12-bit serial chain lets it fill the registers with all zeros to exercise the lock-up fix, and a word width of 8 lets it restart the bit count in the middle of a word.

// File: rtl/rng_pkg.sv
package rng_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_DEBUG = 2'd2
  } mode_e;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr
  import rng_pkg::*;
#(
  parameter int unsigned    LEN  = 29,
  parameter logic [LEN-1:0] TAPS = 29'h1400_0000,
  parameter logic [LEN-1:0] DBG  = 29'h0000_0001
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  step_i,
  input  logic  ser_i,
  output logic  tail_o,
  output logic  zero_o
);
  localparam logic [LEN-1:0] ONE = LEN'(1);

  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb     = ^(state_q & TAPS);
  assign tail_o = state_q[LEN-1];
  assign zero_o = (state_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  state_q <= DBG;
    else if (mode_i == MODE_DEBUG) state_q <= DBG;
    else if (mode_i == MODE_LOAD)  state_q <= {state_q[LEN-2:0], ser_i};
    else if (zero_o)               state_q <= ONE;
    else if (step_i)               state_q <= {state_q[LEN-2:0], fb};
  end

  // R8
  a_r8_debug_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_DEBUG |=> state_q == DBG);
  // R6
  a_r6_serial_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_LOAD |=> state_q[0] == $past(ser_i));
  // R9
  a_r9_zero_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RUN && zero_o) |=> state_q == ONE);
  // R2
  a_r2_no_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RUN && step_i && !zero_o) |=> !zero_o);
endmodule

// File: rtl/rng_packer.sv
module rng_packer #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              bit_i,
  output logic              bit_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] acc_q, acc_nxt;

  generate
    if (WORD_W > 1) begin : g_wide
      assign acc_nxt = {bit_i, acc_q[WORD_W-1:1]};
    end else begin : g_single
      assign acc_nxt = bit_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      word_o  <= '0;
      bit_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else if (step_i) begin
      bit_o <= bit_i;
      acc_q <= acc_nxt;
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        word_o  <= acc_nxt;
        valid_o <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        valid_o <= 1'b0;
      end
    end else begin
      valid_o <= 1'b0;
    end
  end

  // R7
  a_r7_held_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!valid_o && $stable(bit_o) && $stable(word_o)));
  // R5
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> ($stable(bit_o) && $stable(word_o) && !valid_o));
  // R4
  a_r4_word_only_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
endmodule

// File: rtl/rng_combo_top.sv
module rng_combo_top
  import rng_pkg::*;
#(
  parameter int unsigned   LEN_A  = 29,
  parameter int unsigned   LEN_B  = 31,
  parameter int unsigned   LEN_C  = 33,
  parameter logic [LEN_A-1:0] TAPS_A = 29'h1400_0000,
  parameter logic [LEN_B-1:0] TAPS_B = 31'h4800_0000,
  parameter logic [LEN_C-1:0] TAPS_C = 33'h1_0008_0000,
  parameter logic [LEN_A-1:0] DBG_A  = 29'h0ACE_1234,
  parameter logic [LEN_B-1:0] DBG_B  = 31'h1357_9BDF,
  parameter logic [LEN_C-1:0] DBG_C  = 33'h0_2468_ACE1,
  parameter int unsigned   WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_bit_i,
  input  logic              seed_valid_i,
  input  logic              debug_seed_sel_i,
  input  logic              en_i,
  output logic              bit_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  mode_e mode;
  logic  tail_a, tail_b, tail_c;
  logic  zero_a, zero_b, zero_c;
  logic  any_zero, step, comb;

  assign mode = debug_seed_sel_i ? MODE_DEBUG :
                seed_valid_i     ? MODE_LOAD  : MODE_RUN;
  assign any_zero = zero_a | zero_b | zero_c;
  assign step     = en_i && (mode == MODE_RUN) && !any_zero;
  assign comb     = tail_a ^ tail_b ^ tail_c;

  rng_lfsr #(.LEN(LEN_A), .TAPS(TAPS_A), .DBG(DBG_A)) u_a (
    .clk_i, .rst_ni, .mode_i(mode), .step_i(step), .ser_i(seed_bit_i),
    .tail_o(tail_a), .zero_o(zero_a));
  rng_lfsr #(.LEN(LEN_B), .TAPS(TAPS_B), .DBG(DBG_B)) u_b (
    .clk_i, .rst_ni, .mode_i(mode), .step_i(step), .ser_i(tail_a),
    .tail_o(tail_b), .zero_o(zero_b));
  rng_lfsr #(.LEN(LEN_C), .TAPS(TAPS_C), .DBG(DBG_C)) u_c (
    .clk_i, .rst_ni, .mode_i(mode), .step_i(step), .ser_i(tail_b),
    .tail_o(tail_c), .zero_o(zero_c));

  rng_packer #(.WORD_W(WORD_W)) u_pack (
    .clk_i, .rst_ni, .clear_i(mode != MODE_RUN), .step_i(step), .bit_i(comb),
    .bit_o(bit_o), .word_o(word_o), .valid_o(word_valid_o));

  // R3
  a_r3_bit_is_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> bit_o == $past(comb));
  // R7
  a_r7_no_valid_in_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_valid_i || debug_seed_sel_i) |=> !word_valid_o);
endmodule

// File: tb/tb_rng_combo_top.sv
module tb_rng_combo_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int PERIOD = 7 * 15 * 31;
  localparam logic [2:0] DA = 3'b101;
  localparam logic [3:0] DB = 4'b0011;
  localparam logic [4:0] DC = 5'b10001;

  logic clk = 0, rst_ni = 0;
  logic seed_bit = 0, seed_valid = 0, dbg = 0, en = 0;
  logic bit_o, word_valid_o;
  logic [W-1:0] word_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_combo_top #(
    .LEN_A(3), .LEN_B(4), .LEN_C(5),
    .TAPS_A(3'b110), .TAPS_B(4'b1100), .TAPS_C(5'b10100),
    .DBG_A(DA), .DBG_B(DB), .DBG_C(DC), .WORD_W(W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .seed_bit_i(seed_bit), .seed_valid_i(seed_valid),
    .debug_seed_sel_i(dbg), .en_i(en), .bit_o(bit_o), .word_o(word_o),
    .word_valid_o(word_valid_o));

  typedef struct {
    logic b; logic v; logic [W-1:0] w; string tag; int idx;
  } exp_t;
  exp_t q[$];

  // reference model
  logic [2:0] ma; logic [3:0] mb; logic [4:0] mc;
  int mcnt; logic [W-1:0] macc, mword; logic mbit, mv;
  bit rec [0:2*PERIOD];

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic model_reset();
    ma = DA; mb = DB; mc = DC; mcnt = 0; macc = '0; mword = '0; mbit = 0; mv = 0;
  endtask

  task automatic tick(bit e, bit sv, bit sb, bit d, string tag, int idx = -1);
    exp_t it;
    logic c;
    en = e; seed_valid = sv; seed_bit = sb; dbg = d;
    if (d) begin
      ma = DA; mb = DB; mc = DC; mcnt = 0; mv = 0;
    end else if (sv) begin
      mc = {mc[3:0], mb[3]}; mb = {mb[2:0], ma[2]}; ma = {ma[1:0], sb};
      mcnt = 0; mv = 0;
    end else if (ma == 0 || mb == 0 || mc == 0) begin
      if (ma == 0) ma = 3'd1;
      if (mb == 0) mb = 4'd1;
      if (mc == 0) mc = 5'd1;
      mv = 0;
    end else if (e) begin
      c = ma[2] ^ mb[3] ^ mc[4];
      mbit = c;
      macc = {c, macc[W-1:1]};
      if (mcnt == W-1) begin mword = macc; mv = 1; mcnt = 0; end
      else begin mcnt++; mv = 0; end
      ma = {ma[1:0], ^(ma & 3'b110)};
      mb = {mb[2:0], ^(mb & 4'b1100)};
      mc = {mc[3:0], ^(mc & 5'b10100)};
    end else mv = 0;
    it.b = mbit; it.v = mv; it.w = mword; it.tag = tag; it.idx = idx;
    q.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check(it.tag, "bit_o", W'(bit_o), W'(it.b));
      check(it.tag, "word_valid_o", W'(word_valid_o), W'(it.v));
      check(it.tag, "word_o", word_o, it.w);
      if (it.idx >= 0) rec[it.idx] = bit_o;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] pat;
    int mism;
    model_reset();
    #(CLK_PERIOD * 2 + 3);
    check("R1", "bit_o", W'(bit_o), '0);
    check("R1", "word_o", word_o, '0);
    check("R1", "word_valid_o", W'(word_valid_o), '0);
    @(negedge clk);
    rst_ni = 1;

    for (int i = 0; i < 40; i++) tick(1, 0, 0, 0, "R3_R4");
    for (int i = 0; i < 30; i++) tick(i % 3 == 0, 0, 0, 0, "R5");
    pat = 12'b1011_0011_1010;
    for (int i = 0; i < 12; i++) tick(1, 1, pat[i], 0, "R7");
    for (int i = 0; i < 40; i++) tick(1, 0, 0, 0, "R6");
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, "R7");
    tick(1, 1, 1, 0, "R7");
    for (int i = 0; i < 20; i++) tick(1, 0, 0, 0, "R7");
    tick(1, 1, 0, 1, "R8");
    tick(0, 1, 1, 1, "R8");
    for (int i = 0; i < 20; i++) tick(1, 0, 0, 0, "R8");
    for (int i = 0; i < 12; i++) tick(1, 1, 0, 0, "R7");
    tick(0, 0, 0, 0, "R9");
    for (int i = 0; i < 30; i++) tick(1, 0, 0, 0, "R9");

    tick(0, 0, 0, 1, "R8");
    for (int i = 0; i <= 2 * PERIOD; i++) tick(1, 0, 0, 0, "R10", i);
    @(posedge clk); #3;

    mism = 0;
    for (int i = 0; i < PERIOD; i++) if (rec[i] != rec[i + PERIOD]) mism++;
    check("R10", "mismatches at full period", W'(mism), '0);
    foreach (pat[k]) if (k < 3) begin
      int lag;
      lag = (k == 0) ? PERIOD / 3 : (k == 1) ? PERIOD / 5 : PERIOD / 7;
      mism = 0;
      for (int i = 0; i < PERIOD; i++) if (rec[i] != rec[i + lag]) mism++;
      check("R10", "stream differs at shorter lag", W'(mism != 0), W'(1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule